// File: doc/BRIEF.md
# Operand Addressing-Mode Register Update Unit

This unit serves one operand of an instruction. It takes a 3-bit addressing mode and a 3-bit register number. From them it works out four things:

- whether the operand lives in the register itself;
- the first memory address to touch;
- whether that access yields only a pointer, so a second indirect access follows;
- how the selected general register must be updated.

Alongside the mode and register number it receives the register's current contents, an operand-size flag (byte or word) and, for the indexed modes, the index word that follows the instruction.

Requests are registered and processed in a short fixed pipeline. A pre-decrement is written back in the cycle before the address appears. A post-increment is written back in the cycle after the address appears. This lets the sequencer fold the register file update into the operand access without a separate cycle.

Step size is not simply the operand size. The pointer-indirect increment and decrement modes always move by two. The upper two registers (stack pointer and program counter) always move by two in the direct increment and decrement modes as well, so they stay word-aligned.

Top module: `amu_operand_unit`

## Requirements
- R1: Mode 0 reports the register as the operand (`opnd_is_reg`=1), with no indirect access and no write-back.
- R2: Mode 1 presents the register value as the address. It asks for no indirect access and does no write-back.
- R3: Modes 2 and 3 present the unmodified register value as the address. They write back register+step one cycle after `addr_valid`.
- R4: Modes 4 and 5 write back register−step in the cycle after the request is taken, one cycle before `addr_valid`. The presented address equals that decremented value.
- R5: In modes 2 and 4, registers 0–5 step by 1 when `req_byte`=1 and by 2 when `req_byte`=0.
- R6: Modes 3 and 5 always step by 2, whatever the value of `req_byte`.
- R7: Registers 6 and 7 step by 2 in modes 2 and 4 even when `req_byte`=1.
- R8: Modes 6 and 7 present register+index modulo 2^16 as the address and never assert `wb_en`.
- R9: `need_deferred` is 1 exactly for modes 3, 5 and 7.
- R10: For a request taken at clock edge E, `addr_valid` is high for exactly one cycle after edge E+1.
- R11: While a request is in flight, a new `req_valid` is ignored. This lasts from the edge that takes the request up to and including the edge that issues its post-increment slot. An ignored request produces no `addr_valid` and no `wb_en`.
- R12: After a synchronous reset, `addr_valid` and `wb_en` are 0.
- R13: Whenever `wb_en` is 1, `wb_reg` equals the register number of the request that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand request strobe |
| req_mode | input | 3 | Addressing mode 0–7 |
| req_regnum | input | 3 | General register number |
| req_byte | input | 1 | 1 = byte operand, 0 = word operand |
| req_regval | input | 16 | Current contents of the selected register |
| req_index | input | 16 | Index word for modes 6 and 7 |
| addr_valid | output | 1 | One-cycle strobe: address fields are valid |
| opnd_is_reg | output | 1 | Operand is the register itself |
| opnd_addr | output | 16 | First address to access (0 in mode 0) |
| need_deferred | output | 1 | Word at `opnd_addr` is the operand's address |
| wb_en | output | 1 | Register write-back strobe |
| wb_reg | output | 3 | Register to write |
| wb_data | output | 16 | Value to write |

## Verification
The hardest case to provoke is a second request arriving while an earlier one still owes its post-increment write-back. If it were taken, its pre-decrement would land in the same cycle as the post-increment.

The bench holds `req_valid` high through the busy edges with a different mode and register. It then confirms that the earlier request's write-back is unchanged and that no further address or write-back strobe follows.

Wrap-around cases are driven directly: decrementing from zero, and an index sum crossing 2^16. All 128 combinations of mode, register and size are also driven exhaustively before the seeded random mix.

// File: rtl/amu_pkg.sv
package amu_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_REG         = 3'd0,
    AM_REG_IND     = 3'd1,
    AM_POSTINC     = 3'd2,
    AM_POSTINC_DEF = 3'd3,
    AM_PREDEC      = 3'd4,
    AM_PREDEC_DEF  = 3'd5,
    AM_INDEX       = 3'd6,
    AM_INDEX_DEF   = 3'd7
  } amode_e;

  typedef struct packed {
    logic is_reg;      // operand is the register
    logic deferred;    // an indirect access follows
    logic pre_mod;     // decrement before address
    logic post_mod;    // increment after address
    logic indexed;     // address = reg + index
    logic force_word;  // step is two irrespective of size
  } amode_ctl_t;

endpackage

// File: rtl/amu_mode_decode.sv
module amu_mode_decode
  import amu_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output amode_ctl_t        ctl
);
  always_comb begin
    ctl = '0;
    unique case (amode_e'(mode))
      AM_REG:         ctl.is_reg = 1'b1;
      AM_REG_IND:     ctl = '0;
      AM_POSTINC:     ctl.post_mod = 1'b1;
      AM_POSTINC_DEF: begin
        ctl.post_mod   = 1'b1;
        ctl.deferred   = 1'b1;
        ctl.force_word = 1'b1;
      end
      AM_PREDEC:      ctl.pre_mod = 1'b1;
      AM_PREDEC_DEF:  begin
        ctl.pre_mod    = 1'b1;
        ctl.deferred   = 1'b1;
        ctl.force_word = 1'b1;
      end
      AM_INDEX:       ctl.indexed = 1'b1;
      AM_INDEX_DEF:   begin
        ctl.indexed  = 1'b1;
        ctl.deferred = 1'b1;
      end
      default:        ctl = '0;
    endcase
  end
endmodule

// File: rtl/amu_step_sel.sv
module amu_step_sel
  import amu_pkg::*;
#(
  parameter int REGNUM_W   = 3,
  parameter int ALIGN_FROM = 6,
  parameter bit ALIGN_REGS = 1'b1
) (
  input  amode_ctl_t          ctl,
  input  logic [REGNUM_W-1:0] regnum,
  input  logic                byte_op,
  output logic                step_two
);
  logic aligned_reg;

  generate
    if (ALIGN_REGS) begin : g_align
      assign aligned_reg = (int'(regnum) >= ALIGN_FROM);
    end else begin : g_noalign
      assign aligned_reg = 1'b0;
    end
  endgenerate

  assign step_two = ctl.force_word | aligned_reg | ~byte_op;
endmodule

// File: rtl/amu_addr_calc.sv
module amu_addr_calc
  import amu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  amode_ctl_t        ctl,
  input  logic              step_two,
  input  logic [DATA_W-1:0] regval,
  input  logic [DATA_W-1:0] index,
  output logic [DATA_W-1:0] ea,
  output logic [DATA_W-1:0] reg_dec,
  output logic [DATA_W-1:0] reg_inc
);
  logic [DATA_W-1:0] step;

  assign step    = step_two ? DATA_W'(2) : DATA_W'(1);
  assign reg_dec = regval - step;
  assign reg_inc = regval + step;

  always_comb begin
    if (ctl.is_reg)       ea = '0;
    else if (ctl.indexed) ea = regval + index;
    else if (ctl.pre_mod) ea = reg_dec;
    else                  ea = regval;
  end
endmodule

// File: rtl/amu_operand_unit.sv
module amu_operand_unit
  import amu_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_REGS   = 8,
  parameter int ALIGN_FROM = 6,
  parameter bit ALIGN_REGS = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [MODE_W-1:0]           req_mode,
  input  logic [$clog2(NUM_REGS)-1:0] req_regnum,
  input  logic                        req_byte,
  input  logic [DATA_W-1:0]           req_regval,
  input  logic [DATA_W-1:0]           req_index,
  output logic                        addr_valid,
  output logic                        opnd_is_reg,
  output logic [DATA_W-1:0]           opnd_addr,
  output logic                        need_deferred,
  output logic                        wb_en,
  output logic [$clog2(NUM_REGS)-1:0] wb_reg,
  output logic [DATA_W-1:0]           wb_data
);
  localparam int REGNUM_W = $clog2(NUM_REGS);

  amode_ctl_t        ctl;
  logic              step_two;
  logic [DATA_W-1:0] ea, reg_dec, reg_inc;

  amu_mode_decode u_dec (.mode(req_mode), .ctl(ctl));

  amu_step_sel #(
    .REGNUM_W  (REGNUM_W),
    .ALIGN_FROM(ALIGN_FROM),
    .ALIGN_REGS(ALIGN_REGS)
  ) u_step (
    .ctl     (ctl),
    .regnum  (req_regnum),
    .byte_op (req_byte),
    .step_two(step_two)
  );

  amu_addr_calc #(.DATA_W(DATA_W)) u_calc (
    .ctl     (ctl),
    .step_two(step_two),
    .regval  (req_regval),
    .index   (req_index),
    .ea      (ea),
    .reg_dec (reg_dec),
    .reg_inc (reg_inc)
  );

  // stage 1: request captured
  logic                s1_v;
  amode_ctl_t          s1_ctl;
  logic [REGNUM_W-1:0] s1_reg;
  logic [DATA_W-1:0]   s1_ea, s1_inc;
  // stage 2: address presented, post-increment owed
  logic                s2_v, s2_post;
  logic [REGNUM_W-1:0] s2_reg;
  logic [DATA_W-1:0]   s2_inc;

  logic take;
  assign take = req_valid & ~s1_v & ~s2_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_ctl <= '0;
      s1_reg <= '0;
      s1_ea  <= '0;
      s1_inc <= '0;
    end else begin
      s1_v <= take;
      if (take) begin
        s1_ctl <= ctl;
        s1_reg <= req_regnum;
        s1_ea  <= ea;
        s1_inc <= reg_inc;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v          <= 1'b0;
      s2_post       <= 1'b0;
      s2_reg        <= '0;
      s2_inc        <= '0;
      addr_valid    <= 1'b0;
      opnd_is_reg   <= 1'b0;
      opnd_addr     <= '0;
      need_deferred <= 1'b0;
    end else begin
      s2_v       <= s1_v;
      addr_valid <= s1_v;
      if (s1_v) begin
        s2_post       <= s1_ctl.post_mod;
        s2_reg        <= s1_reg;
        s2_inc        <= s1_inc;
        opnd_is_reg   <= s1_ctl.is_reg;
        opnd_addr     <= s1_ea;
        need_deferred <= s1_ctl.deferred;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en   <= 1'b0;
      wb_reg  <= '0;
      wb_data <= '0;
    end else begin
      wb_en <= 1'b0;
      if (take && ctl.pre_mod) begin
        wb_en   <= 1'b1;
        wb_reg  <= req_regnum;
        wb_data <= reg_dec;
      end else if (s2_v && s2_post) begin
        wb_en   <= 1'b1;
        wb_reg  <= s2_reg;
        wb_data <= s2_inc;
      end
    end
  end
endmodule

// File: rtl/amu_operand_unit_chk.sv
module amu_operand_unit_chk #(
  parameter int DATA_W   = 16,
  parameter int REGNUM_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                take,
  input logic [2:0]          req_mode,
  input logic [REGNUM_W-1:0] req_regnum,
  input logic [DATA_W-1:0]   req_regval,
  input logic                addr_valid,
  input logic                opnd_is_reg,
  input logic                need_deferred,
  input logic                wb_en,
  input logic [REGNUM_W-1:0] wb_reg,
  input logic [DATA_W-1:0]   wb_data
);
  a_r12_reset_quiet: assert property (@(posedge clk)
    rst |=> (!addr_valid && !wb_en));

  a_r10_addr_latency: assert property (@(posedge clk) disable iff (rst)
    take |=> ##1 addr_valid);

  a_r10_addr_single: assert property (@(posedge clk) disable iff (rst)
    addr_valid |=> !addr_valid);

  a_r4_pre_wb: assert property (@(posedge clk) disable iff (rst)
    (take && (req_mode == 3'd4 || req_mode == 3'd5)) |=>
      (wb_en && wb_reg == $past(req_regnum)));

  a_r6_predef_step: assert property (@(posedge clk) disable iff (rst)
    (take && req_mode == 3'd5) |=> (wb_data == $past(req_regval) - DATA_W'(2)));

  a_r3_post_wb: assert property (@(posedge clk) disable iff (rst)
    (take && (req_mode == 3'd2 || req_mode == 3'd3)) |=> !wb_en ##1 !wb_en ##1 wb_en);

  a_r8_no_wb_index: assert property (@(posedge clk) disable iff (rst)
    (take && req_mode[2:1] == 2'b11) |=> !wb_en ##1 !wb_en ##1 !wb_en);

  a_r1_isreg_mode0: assert property (@(posedge clk) disable iff (rst)
    (take && req_mode == 3'd0) |=> ##1 (opnd_is_reg && !need_deferred));

  a_r9_deferred: assert property (@(posedge clk) disable iff (rst)
    (take && (req_mode == 3'd3 || req_mode == 3'd5 || req_mode == 3'd7)) |=> ##1 need_deferred);
endmodule

bind amu_operand_unit amu_operand_unit_chk #(
  .DATA_W  (DATA_W),
  .REGNUM_W($clog2(NUM_REGS))
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .take         (take),
  .req_mode     (req_mode),
  .req_regnum   (req_regnum),
  .req_regval   (req_regval),
  .addr_valid   (addr_valid),
  .opnd_is_reg  (opnd_is_reg),
  .need_deferred(need_deferred),
  .wb_en        (wb_en),
  .wb_reg       (wb_reg),
  .wb_data      (wb_data)
);

// File: tb/amu_operand_unit_tb.sv
module amu_operand_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_mode;
  logic [2:0]  req_regnum;
  logic        req_byte;
  logic [15:0] req_regval;
  logic [15:0] req_index;
  logic        addr_valid, opnd_is_reg, need_deferred, wb_en;
  logic [15:0] opnd_addr, wb_data;
  logic [2:0]  wb_reg;

  int n_tests = 0;
  int n_fail  = 0;
  int seed_v;
  bit done = 0;

  always #4 clk = ~clk;

  amu_operand_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_regnum(req_regnum), .req_byte(req_byte), .req_regval(req_regval),
    .req_index(req_index), .addr_valid(addr_valid), .opnd_is_reg(opnd_is_reg),
    .opnd_addr(opnd_addr), .need_deferred(need_deferred), .wb_en(wb_en),
    .wb_reg(wb_reg), .wb_data(wb_data)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_step(input logic [2:0] m, input logic [2:0] r, input logic b);
    if (m == 3'd3 || m == 3'd5) return 16'd2;      // R6
    if (r >= 3'd6) return 16'd2;                   // R7
    return b ? 16'd1 : 16'd2;                      // R5
  endfunction

  function automatic logic [15:0] ref_addr(input logic [2:0] m, input logic [15:0] v,
                                           input logic [15:0] ix, input logic [15:0] st);
    case (m)
      3'd0:       return 16'd0;
      3'd4, 3'd5: return v - st;
      3'd6, 3'd7: return v + ix;
      default:    return v;
    endcase
  endfunction

  task automatic run_req(input logic [2:0] m, input logic [2:0] r, input logic b,
                         input logic [15:0] v, input logic [15:0] ix);
    logic [15:0] st;
    logic        pre, post;
    st   = ref_step(m, r, b);
    pre  = (m == 3'd4 || m == 3'd5);
    post = (m == 3'd2 || m == 3'd3);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_regnum = r; req_byte = b;
    req_regval = v; req_index = ix;
    @(negedge clk);
    req_valid = 1'b0;
    chk(wb_en == pre, "R4", "pre wb_en", 32'(wb_en), 32'(pre));
    if (pre) begin
      chk(wb_data == v - st, "R4", "pre wb_data", 32'(wb_data), 32'(v - st));
      chk(wb_reg == r, "R13", "pre wb_reg", 32'(wb_reg), 32'(r));
    end
    chk(addr_valid == 1'b0, "R10", "early addr_valid", 32'(addr_valid), 0);
    @(negedge clk);
    chk(addr_valid == 1'b1, "R10", "addr_valid", 32'(addr_valid), 1);
    chk(opnd_is_reg == (m == 3'd0), "R1", "opnd_is_reg", 32'(opnd_is_reg), 32'(m == 3'd0));
    chk(need_deferred == (m == 3'd3 || m == 3'd5 || m == 3'd7), "R9", "need_deferred",
        32'(need_deferred), 32'(m == 3'd3 || m == 3'd5 || m == 3'd7));
    if (m != 3'd0)
      chk(opnd_addr == ref_addr(m, v, ix, st), (m >= 3'd6) ? "R8" : "R2", "opnd_addr",
          32'(opnd_addr), 32'(ref_addr(m, v, ix, st)));
    chk(wb_en == 1'b0, "R3", "mid wb_en", 32'(wb_en), 0);
    @(negedge clk);
    chk(wb_en == post, "R3", "post wb_en", 32'(wb_en), 32'(post));
    if (post) begin
      chk(wb_data == v + st, (m == 3'd3) ? "R6" : "R5", "post wb_data",
          32'(wb_data), 32'(v + st));
      chk(wb_reg == r, "R13", "post wb_reg", 32'(wb_reg), 32'(r));
    end
    chk(addr_valid == 1'b0, "R10", "addr_valid single", 32'(addr_valid), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    seed_v = 32'h5eed_1234;
    void'($urandom(seed_v));
    rst = 1'b1; req_valid = 1'b0; req_mode = '0; req_regnum = '0; req_byte = 1'b0;
    req_regval = '0; req_index = '0;
    repeat (3) @(negedge clk);
    chk(addr_valid == 1'b0, "R12", "reset addr_valid", 32'(addr_valid), 0);
    chk(wb_en == 1'b0, "R12", "reset wb_en", 32'(wb_en), 0);
    rst = 1'b0;

    // exhaustive mode x register x size
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < 8; r++)
        for (int b = 0; b < 2; b++)
          run_req(3'(m), 3'(r), 1'(b), 16'h1000 + 16'(r * 16'h11), 16'h0230);

    // directed wrap and alignment corners
    run_req(3'd6, 3'd2, 1'b0, 16'hfff0, 16'h0020);   // R8 wrap
    run_req(3'd7, 3'd3, 1'b1, 16'h8000, 16'h8004);   // R8 wrap
    run_req(3'd4, 3'd1, 1'b0, 16'h0000, 16'h0);      // R4 below zero
    run_req(3'd5, 3'd0, 1'b1, 16'h0001, 16'h0);      // R6 byte deferred
    run_req(3'd2, 3'd7, 1'b1, 16'hfffe, 16'h0);      // R7 pc wrap
    run_req(3'd4, 3'd6, 1'b1, 16'h0100, 16'h0);      // R7 sp byte
    run_req(3'd2, 3'd5, 1'b1, 16'hffff, 16'h0);      // R5 byte wrap

    // R11: requests while busy are ignored
    @(negedge clk);
    req_valid = 1'b1; req_mode = 3'd2; req_regnum = 3'd3; req_byte = 1'b0;
    req_regval = 16'h4000; req_index = 16'h0;
    @(negedge clk);
    req_mode = 3'd4; req_regnum = 3'd1; req_regval = 16'h7777;  // held while busy
    chk(wb_en == 1'b0, "R11", "busy wb_en E0", 32'(wb_en), 0);
    @(negedge clk);
    chk(addr_valid == 1'b1 && opnd_addr == 16'h4000, "R11", "busy addr",
        32'(opnd_addr), 32'h4000);
    chk(wb_en == 1'b0, "R11", "busy wb_en E1", 32'(wb_en), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(wb_en == 1'b1 && wb_data == 16'h4002 && wb_reg == 3'd3, "R11", "post wb kept",
        32'(wb_data), 32'h4002);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!addr_valid && !wb_en, "R11", "ignored request quiet",
          32'({addr_valid, wb_en}), 0);
    end

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [2:0]  m, r;
      logic        b;
      logic [15:0] v, ix;
      m  = 3'($urandom());
      r  = 3'($urandom());
      b  = 1'($urandom());
      v  = 16'($urandom());
      ix = 16'($urandom());
      if (($urandom() % 8) == 0) v = 16'hffff - 16'($urandom() % 3);
      run_req(m, r, b, v, ix);
    end

    // reset mid-flight
    @(negedge clk);
    req_valid = 1'b1; req_mode = 3'd2; req_regnum = 3'd0; req_regval = 16'h10;
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(!addr_valid && !wb_en, "R12", "reset flush", 32'({addr_valid, wb_en}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!addr_valid && !wb_en, "R12", "after reset quiet", 32'({addr_valid, wb_en}), 0);

    finish_run();
  end
endmodule